// File: doc/BRIEF.md
# LCD Frame Fetch Sequencer

This block is the per-frame control engine of a display controller that reads its pixels from memory. When software turns the panel on, the engine first asks an external address checker whether each edge of the frame buffer windows is legal. It checks one buffer, or two when ping-pong operation is selected. Unless the load mode says the palette is already in place, it then fetches a 256-word, 16-bit colour table from the start of the current buffer. It does this over a simple request/valid read port, one word per request.

After that it waits for frame ticks. On each tick it re-reads the first word of the buffer, which is the table header, unless the load mode has no header. From a 3-bit depth code in that word it derives the pixel depth, the size of the header in front of the pixels, and the number of bytes the frame needs. It then either skips the frame, flags an under-sized buffer and shuts itself off, or hands the downstream pixel unpacker a one-cycle frame-start strobe. That strobe carries the pixel start address, the line stride, the first line and the line count. Good frames set a per-buffer condition bit and may pulse a DMA interrupt. In ping-pong mode the engine swaps buffers after every good frame.

Top module: `lcd_fetch_seq`

## Requirements
- R1: On an enable that changes the state from off to on, the engine presents `buf0_top`, `buf0_bot` and, only if `dual` is 1, `buf1_top` and `buf1_bot` on `chk_addr`, one per cycle. A 0 on `chk_ok` for any of them sets `dma_cond[2]`, pulses `dma_irq_err` for one cycle if `dma_mask[1]` is 1, and clears `active`.
- R2: After the checks, if `load_mode` is not 2 and `pal_loaded` is 0, the engine reads 256 words at byte addresses top+2k of the current buffer into the colour table, readable at `pal_rdata` via `pal_raddr`, and then sets `pal_loaded`. With `load_mode` 2 no table is fetched.
- R3: The depth code is bits 14:12 of the header word. Code 1 gives `fs_bpp` 2, code 2 gives 4, code 3 gives 8, and codes 4 to 7 give 16 with `fs_fmt12` 1 when `tft` is 0. Code 0 skips the frame with no strobe and no condition bit.
- R4: `fs_addr` is the buffer top plus a header of 0x200 bytes for code 3 or more, or 0x20 bytes below that, or 0 when `load_mode` is 2. In mode 2 the header word is the last one fetched.
- R5: If header + width*height*bpp/8 is greater than (bottom - top) + 2 of the current buffer, the frame gives no strobe, `sync_err` is set and `active` is cleared. Equality is a good frame.
- R6: A good frame sets `dma_cond[idx]`, pulses `dma_irq_frame` if `dma_mask[0]` is 1, and flips idx when `dual` is 1. Buffer 0 is used first.
- R7: Enabling from the idle index selects buffer 0 and clears `frame_done` and `pal_loaded`. Disabling returns the index to idle and clears `sync_err`. It also sets `frame_done` unless `load_mode` is 1.
- R8: With `sub_en` 1, `sub_val` gives `fs_first` when `sub_first` is 1, or `fs_lines` when it is 0. Otherwise the first line is 0 and the line count is height_m1+1.
- R9: With `load_mode` 1, frame ticks produce nothing.
- R10: `fs_stride` equals width*bpp/8. `fs_valid` is high for exactly one cycle per good frame.
- R11: `lcd_irq` is high when `frame_done` and `lcd_mask[0]` are both 1, or `pal_loaded` and `lcd_mask[1]` are both 1, or `sync_err` is 1.
- R12: An enable write equal to the current `active` value has no effect. For example, writing 0 after a size fault leaves `frame_done` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en_wr | input | 1 | Enable write strobe |
| en_val | input | 1 | Enable value written |
| load_mode | input | 2 | Table/frame load mode |
| tft | input | 1 | Active-matrix panel select |
| dual | input | 1 | Ping-pong buffer mode |
| width_m1 | input | DIM_W | Pixels per line minus one |
| height_m1 | input | DIM_W | Lines per frame minus one |
| buf0_top | input | ADDR_W | Buffer 0 first byte |
| buf0_bot | input | ADDR_W | Buffer 0 last byte |
| buf1_top | input | ADDR_W | Buffer 1 first byte |
| buf1_bot | input | ADDR_W | Buffer 1 last byte |
| sub_en | input | 1 | Sub-panel enable |
| sub_first | input | 1 | Sub-panel value is first line (else line count) |
| sub_val | input | DIM_W | Sub-panel line value |
| lcd_mask | input | 2 | Panel interrupt mask (frame-done, table-loaded) |
| dma_mask | input | 2 | DMA interrupt mask (frame, error) |
| frame_tick | input | 1 | Frame start request |
| chk_addr | output | ADDR_W | Address offered for legality check |
| chk_ok | input | 1 | Checked address is legal |
| rd_req | output | 1 | Memory read request pulse |
| rd_addr | output | ADDR_W | Memory read byte address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | DATA_W | Read data |
| pal_raddr | input | PAL_AW | Colour table read index |
| pal_rdata | output | DATA_W | Colour table read data |
| active | output | 1 | Panel enabled |
| frame_done | output | 1 | Frame-done flag |
| pal_loaded | output | 1 | Table-loaded flag |
| sync_err | output | 1 | Buffer-size fault flag |
| lcd_irq | output | 1 | Panel interrupt level |
| dma_cond | output | 3 | Sticky DMA condition bits |
| dma_irq_frame | output | 1 | DMA frame interrupt pulse |
| dma_irq_err | output | 1 | DMA address-error interrupt pulse |
| fs_valid | output | 1 | Frame-start strobe |
| fs_addr | output | ADDR_W | Pixel start address |
| fs_stride | output | DIM_W+2 | Line stride in bytes |
| fs_first | output | DIM_W | First line |
| fs_lines | output | DIM_W+1 | Line count |
| fs_bpp | output | 5 | Bits per pixel |
| fs_fmt12 | output | 1 | 12-bit colour format |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 10-bit dimensions and a full 256-word 16-bit table. Keeping the full table depth puts the last-index wrap of the table fetch within reach, and the bench checks it by reading entry 255 back. A small 16x8 frame then lets each depth code land its byte count just inside, exactly on, or one byte beyond the buffer room. This exercises the equality edge of the size fault without long runs. The 32-bit address lets the bench mark a buffer illegal with the top address bit alone.

// File: rtl/lcd_fs_pkg.sv
package lcd_fs_pkg;

    // depth code position inside the header word
    localparam int CODE_LSB = 12;
    localparam int CODE_W   = 3;

    // header sizes in bytes
    localparam int HDR_LARGE = 512;
    localparam int HDR_SMALL = 32;

    // load mode encodings that change behaviour
    localparam logic [1:0] LM_NO_FETCH = 2'd1;
    localparam logic [1:0] LM_NO_TABLE = 2'd2;

    // condition bit raised on an illegal buffer address
    localparam int COND_ERR_BIT = 2;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CHK0_T,
        S_CHK0_B,
        S_CHK1_T,
        S_CHK1_B,
        S_TBL_REQ,
        S_TBL_WAIT,
        S_RUN,
        S_HDR_REQ,
        S_HDR_WAIT,
        S_EVAL
    } seq_state_e;

endpackage

// File: rtl/lcd_fs_geom.sv
module lcd_fs_geom
    import lcd_fs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DIM_W  = 10
) (
    input  logic [CODE_W-1:0] depth_code,
    input  logic [1:0]        load_mode,
    input  logic              tft,
    input  logic [DIM_W-1:0]  width_m1,
    input  logic [DIM_W-1:0]  height_m1,
    input  logic [ADDR_W-1:0] top,
    input  logic [ADDR_W-1:0] bot,
    input  logic              sub_en,
    input  logic              sub_first,
    input  logic [DIM_W-1:0]  sub_val,
    output logic              skip,
    output logic              fault,
    output logic [ADDR_W-1:0] start_addr,
    output logic [DIM_W+1:0]  stride,
    output logic [DIM_W-1:0]  first,
    output logic [DIM_W:0]    lines,
    output logic [4:0]        bpp,
    output logic              fmt12
);
    localparam int DIM1_W  = DIM_W + 1;
    localparam int PIX_W   = 2 * DIM1_W;
    localparam int NEED_W  = PIX_W + 6;
    localparam int LINE_W  = DIM1_W + 5;
    localparam int CMP_W   = ((NEED_W > ADDR_W) ? NEED_W : ADDR_W) + 2;

    logic [DIM1_W-1:0] width_px;
    logic [DIM1_W-1:0] height_px;
    logic [PIX_W-1:0]  pix_cnt;
    logic [NEED_W-1:0] bit_cnt;
    logic [NEED_W-1:0] need_bytes;
    logic [NEED_W-1:0] hdr_bytes;
    logic [LINE_W-1:0] line_bits;
    logic signed [CMP_W-1:0] room;
    logic signed [CMP_W-1:0] need_s;

    always_comb begin
        skip  = 1'b0;
        unique case (depth_code)
            3'd0:    begin bpp = 5'd0; skip = 1'b1; end
            3'd1:    bpp = 5'd2;
            3'd2:    bpp = 5'd4;
            3'd3:    bpp = 5'd8;
            default: bpp = 5'd16;
        endcase
        fmt12 = (depth_code >= 3'd4) && !tft;

        if (load_mode == LM_NO_TABLE)
            hdr_bytes = '0;
        else if (depth_code >= 3'd3)
            hdr_bytes = NEED_W'(HDR_LARGE);
        else
            hdr_bytes = NEED_W'(HDR_SMALL);

        width_px   = DIM1_W'(width_m1) + DIM1_W'(1);
        height_px  = DIM1_W'(height_m1) + DIM1_W'(1);
        pix_cnt    = PIX_W'(width_px) * PIX_W'(height_px);
        bit_cnt    = NEED_W'(pix_cnt) * NEED_W'(bpp);
        need_bytes = (bit_cnt >> 3) + hdr_bytes;

        room   = $signed(CMP_W'(bot)) - $signed(CMP_W'(top)) + CMP_W'(2);
        need_s = $signed(CMP_W'(need_bytes));
        fault  = !skip && (need_s > room);

        line_bits  = LINE_W'(width_px) * LINE_W'(bpp);
        stride     = (DIM_W+2)'(line_bits >> 3);
        start_addr = top + ADDR_W'(hdr_bytes);

        first = '0;
        lines = height_px;
        if (sub_en) begin
            if (sub_first) first = sub_val;
            else           lines = DIM1_W'(sub_val);
        end
    end

endmodule

// File: rtl/lcd_fs_palram.sv
module lcd_fs_palram #(
    parameter int DATA_W = 16,
    parameter int WORDS  = 256,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/lcd_fs_ctrl.sv
module lcd_fs_ctrl
    import lcd_fs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DIM_W  = 10,
    parameter int DATA_W = 16,
    parameter int WORDS  = 256,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic              en_val,
    input  logic [1:0]        load_mode,
    input  logic              dual,
    input  logic [ADDR_W-1:0] buf0_top,
    input  logic [ADDR_W-1:0] buf0_bot,
    input  logic [ADDR_W-1:0] buf1_top,
    input  logic [ADDR_W-1:0] buf1_bot,
    input  logic [1:0]        dma_mask,
    input  logic              frame_tick,
    output logic [ADDR_W-1:0] chk_addr,
    input  logic              chk_ok,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    // geometry of the current buffer
    output logic [ADDR_W-1:0] cur_top,
    output logic [ADDR_W-1:0] cur_bot,
    output logic [DATA_W-1:0] hdr_word,
    input  logic              g_skip,
    input  logic              g_fault,
    input  logic [ADDR_W-1:0] g_start,
    input  logic [DIM_W+1:0]  g_stride,
    input  logic [DIM_W-1:0]  g_first,
    input  logic [DIM_W:0]    g_lines,
    input  logic [4:0]        g_bpp,
    input  logic              g_fmt12,
    // table write port
    output logic              tbl_we,
    output logic [AW-1:0]     tbl_waddr,
    output logic [DATA_W-1:0] tbl_wdata,
    // state
    output logic              active,
    output logic              frame_done,
    output logic              pal_loaded,
    output logic              sync_err,
    output logic [2:0]        dma_cond,
    output logic              dma_irq_frame,
    output logic              dma_irq_err,
    output logic              fs_valid,
    output logic [ADDR_W-1:0] fs_addr,
    output logic [DIM_W+1:0]  fs_stride,
    output logic [DIM_W-1:0]  fs_first,
    output logic [DIM_W:0]    fs_lines,
    output logic [4:0]        fs_bpp,
    output logic              fs_fmt12
);
    localparam logic [AW-1:0] LAST_WORD = AW'(WORDS - 1);

    typedef struct packed {
        seq_state_e        state;
        logic              active;
        logic              idx;
        logic              idx_idle;
        logic              pal_loaded;
        logic              frame_done;
        logic              sync_err;
        logic [2:0]        cond;
        logic              irq_frame;
        logic              irq_err;
        logic [AW-1:0]     wcnt;
        logic [DATA_W-1:0] hdr;
        logic              fs_valid;
        logic [ADDR_W-1:0] fs_addr;
        logic [DIM_W+1:0]  fs_stride;
        logic [DIM_W-1:0]  fs_first;
        logic [DIM_W:0]    fs_lines;
        logic [4:0]        fs_bpp;
        logic              fs_fmt12;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        cur_top = seq_q.idx ? buf1_top : buf0_top;
        cur_bot = seq_q.idx ? buf1_bot : buf0_bot;
    end

    always_comb begin
        seq_d           = seq_q;
        seq_d.irq_frame = 1'b0;
        seq_d.irq_err   = 1'b0;
        seq_d.fs_valid  = 1'b0;
        chk_addr        = '0;
        rd_req          = 1'b0;
        rd_addr         = cur_top + ADDR_W'({seq_q.wcnt, 1'b0});
        tbl_we          = 1'b0;
        tbl_waddr       = seq_q.wcnt;
        tbl_wdata       = rd_data;

        if (en_wr && !en_val && seq_q.active) begin
            // turning off from any busy state
            seq_d.state    = S_IDLE;
            seq_d.active   = 1'b0;
            seq_d.idx      = 1'b0;
            seq_d.idx_idle = 1'b1;
            seq_d.sync_err = 1'b0;
            if (load_mode != LM_NO_FETCH) seq_d.frame_done = 1'b1;
        end else begin
            unique case (seq_q.state)
                S_IDLE: begin
                    if (en_wr && en_val) begin
                        seq_d.active = 1'b1;
                        seq_d.state  = S_CHK0_T;
                        if (seq_q.idx_idle) begin
                            seq_d.idx        = 1'b0;
                            seq_d.idx_idle   = 1'b0;
                            seq_d.frame_done = 1'b0;
                            seq_d.pal_loaded = 1'b0;
                        end
                    end
                end
                S_CHK0_T, S_CHK0_B, S_CHK1_T, S_CHK1_B: begin
                    unique case (seq_q.state)
                        S_CHK0_T: chk_addr = buf0_top;
                        S_CHK0_B: chk_addr = buf0_bot;
                        S_CHK1_T: chk_addr = buf1_top;
                        default:  chk_addr = buf1_bot;
                    endcase
                    if (!chk_ok) begin
                        seq_d.cond[COND_ERR_BIT] = 1'b1;
                        seq_d.irq_err = dma_mask[1];
                        seq_d.active  = 1'b0;
                        seq_d.state   = S_IDLE;
                    end else if (seq_q.state == S_CHK0_T) begin
                        seq_d.state = S_CHK0_B;
                    end else if (seq_q.state == S_CHK1_T) begin
                        seq_d.state = S_CHK1_B;
                    end else if (seq_q.state == S_CHK0_B && dual) begin
                        seq_d.state = S_CHK1_T;
                    end else if (load_mode != LM_NO_TABLE && !seq_q.pal_loaded) begin
                        seq_d.wcnt  = '0;
                        seq_d.state = S_TBL_REQ;
                    end else begin
                        seq_d.state = S_RUN;
                    end
                end
                S_TBL_REQ: begin
                    rd_req      = 1'b1;
                    seq_d.state = S_TBL_WAIT;
                end
                S_TBL_WAIT: begin
                    if (rd_valid) begin
                        tbl_we = 1'b1;
                        if (seq_q.wcnt == '0) seq_d.hdr = rd_data;
                        if (seq_q.wcnt == LAST_WORD) begin
                            seq_d.pal_loaded = 1'b1;
                            seq_d.state      = S_RUN;
                        end else begin
                            seq_d.wcnt  = seq_q.wcnt + AW'(1);
                            seq_d.state = S_TBL_REQ;
                        end
                    end
                end
                S_RUN: begin
                    if (frame_tick && load_mode != LM_NO_FETCH) begin
                        seq_d.state = (load_mode == LM_NO_TABLE) ? S_EVAL : S_HDR_REQ;
                    end
                end
                S_HDR_REQ: begin
                    rd_req      = 1'b1;
                    rd_addr     = cur_top;
                    seq_d.state = S_HDR_WAIT;
                end
                S_HDR_WAIT: begin
                    if (rd_valid) begin
                        tbl_we      = 1'b1;
                        tbl_waddr   = '0;
                        seq_d.hdr   = rd_data;
                        seq_d.state = S_EVAL;
                    end
                end
                S_EVAL: begin
                    seq_d.state = S_RUN;
                    if (g_skip) begin
                        seq_d.state = S_RUN;
                    end else if (g_fault) begin
                        seq_d.sync_err = 1'b1;
                        seq_d.active   = 1'b0;
                        seq_d.state    = S_IDLE;
                    end else begin
                        seq_d.cond[seq_q.idx] = 1'b1;
                        seq_d.irq_frame = dma_mask[0];
                        if (dual) seq_d.idx = ~seq_q.idx;
                        seq_d.fs_valid  = 1'b1;
                        seq_d.fs_addr   = g_start;
                        seq_d.fs_stride = g_stride;
                        seq_d.fs_first  = g_first;
                        seq_d.fs_lines  = g_lines;
                        seq_d.fs_bpp    = g_bpp;
                        seq_d.fs_fmt12  = g_fmt12;
                    end
                end
                default: seq_d.state = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q          <= '0;
            seq_q.state    <= S_IDLE;
            seq_q.idx_idle <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign hdr_word      = seq_q.hdr;
    assign active        = seq_q.active;
    assign frame_done    = seq_q.frame_done;
    assign pal_loaded    = seq_q.pal_loaded;
    assign sync_err      = seq_q.sync_err;
    assign dma_cond      = seq_q.cond;
    assign dma_irq_frame = seq_q.irq_frame;
    assign dma_irq_err   = seq_q.irq_err;
    assign fs_valid      = seq_q.fs_valid;
    assign fs_addr       = seq_q.fs_addr;
    assign fs_stride     = seq_q.fs_stride;
    assign fs_first      = seq_q.fs_first;
    assign fs_lines      = seq_q.fs_lines;
    assign fs_bpp        = seq_q.fs_bpp;
    assign fs_fmt12      = seq_q.fs_fmt12;

endmodule

// File: rtl/lcd_fetch_seq.sv
module lcd_fetch_seq
    import lcd_fs_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DIM_W     = 10,
    parameter int DATA_W    = 16,
    parameter int PAL_WORDS = 256,
    localparam int PAL_AW   = $clog2(PAL_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic              en_val,
    input  logic [1:0]        load_mode,
    input  logic              tft,
    input  logic              dual,
    input  logic [DIM_W-1:0]  width_m1,
    input  logic [DIM_W-1:0]  height_m1,
    input  logic [ADDR_W-1:0] buf0_top,
    input  logic [ADDR_W-1:0] buf0_bot,
    input  logic [ADDR_W-1:0] buf1_top,
    input  logic [ADDR_W-1:0] buf1_bot,
    input  logic              sub_en,
    input  logic              sub_first,
    input  logic [DIM_W-1:0]  sub_val,
    input  logic [1:0]        lcd_mask,
    input  logic [1:0]        dma_mask,
    input  logic              frame_tick,
    output logic [ADDR_W-1:0] chk_addr,
    input  logic              chk_ok,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [PAL_AW-1:0] pal_raddr,
    output logic [DATA_W-1:0] pal_rdata,
    output logic              active,
    output logic              frame_done,
    output logic              pal_loaded,
    output logic              sync_err,
    output logic              lcd_irq,
    output logic [2:0]        dma_cond,
    output logic              dma_irq_frame,
    output logic              dma_irq_err,
    output logic              fs_valid,
    output logic [ADDR_W-1:0] fs_addr,
    output logic [DIM_W+1:0]  fs_stride,
    output logic [DIM_W-1:0]  fs_first,
    output logic [DIM_W:0]    fs_lines,
    output logic [4:0]        fs_bpp,
    output logic              fs_fmt12
);
    logic [ADDR_W-1:0] cur_top, cur_bot, g_start;
    logic [DATA_W-1:0] hdr_word, tbl_wdata;
    logic              g_skip, g_fault, g_fmt12, tbl_we;
    logic [DIM_W+1:0]  g_stride;
    logic [DIM_W-1:0]  g_first;
    logic [DIM_W:0]    g_lines;
    logic [4:0]        g_bpp;
    logic [PAL_AW-1:0] tbl_waddr;

    lcd_fs_ctrl #(
        .ADDR_W(ADDR_W), .DIM_W(DIM_W), .DATA_W(DATA_W), .WORDS(PAL_WORDS)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_val(en_val),
        .load_mode(load_mode), .dual(dual),
        .buf0_top(buf0_top), .buf0_bot(buf0_bot),
        .buf1_top(buf1_top), .buf1_bot(buf1_bot),
        .dma_mask(dma_mask), .frame_tick(frame_tick),
        .chk_addr(chk_addr), .chk_ok(chk_ok),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .cur_top(cur_top), .cur_bot(cur_bot), .hdr_word(hdr_word),
        .g_skip(g_skip), .g_fault(g_fault), .g_start(g_start), .g_stride(g_stride),
        .g_first(g_first), .g_lines(g_lines), .g_bpp(g_bpp), .g_fmt12(g_fmt12),
        .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
        .active(active), .frame_done(frame_done), .pal_loaded(pal_loaded),
        .sync_err(sync_err), .dma_cond(dma_cond),
        .dma_irq_frame(dma_irq_frame), .dma_irq_err(dma_irq_err),
        .fs_valid(fs_valid), .fs_addr(fs_addr), .fs_stride(fs_stride),
        .fs_first(fs_first), .fs_lines(fs_lines), .fs_bpp(fs_bpp), .fs_fmt12(fs_fmt12)
    );

    lcd_fs_geom #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_geom (
        .depth_code(hdr_word[CODE_LSB +: CODE_W]),
        .load_mode(load_mode), .tft(tft),
        .width_m1(width_m1), .height_m1(height_m1),
        .top(cur_top), .bot(cur_bot),
        .sub_en(sub_en), .sub_first(sub_first), .sub_val(sub_val),
        .skip(g_skip), .fault(g_fault), .start_addr(g_start), .stride(g_stride),
        .first(g_first), .lines(g_lines), .bpp(g_bpp), .fmt12(g_fmt12)
    );

    lcd_fs_palram #(.DATA_W(DATA_W), .WORDS(PAL_WORDS)) u_tbl (
        .clk(clk), .we(tbl_we), .waddr(tbl_waddr), .wdata(tbl_wdata),
        .raddr(pal_raddr), .rdata(pal_rdata)
    );

    assign lcd_irq = (frame_done & lcd_mask[0]) | (pal_loaded & lcd_mask[1]) | sync_err;

endmodule

// File: rtl/lcd_fetch_seq_chk.sv
module lcd_fetch_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int DIM_W  = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             active,
    input logic             sync_err,
    input logic [2:0]       dma_cond,
    input logic             dma_irq_frame,
    input logic             dma_irq_err,
    input logic             rd_req,
    input logic             sub_en,
    input logic [DIM_W-1:0] height_m1,
    input logic             fs_valid,
    input logic [DIM_W-1:0] fs_first,
    input logic [DIM_W:0]   fs_lines,
    input logic [4:0]       fs_bpp
);
    // R1
    addr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_irq_err |-> (dma_cond[2] && !active));

    // R2
    read_when_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> active);

    // R3
    depth_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fs_valid |-> ($onehot(fs_bpp[4:1]) && !fs_bpp[0]));

    // R5
    fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_err) |-> !active);

    // R6
    good_frame_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fs_valid |-> active);

    // R6
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dma_irq_frame, dma_irq_err}));

    // R8
    full_panel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_valid && !sub_en) |-> (fs_first == '0 && fs_lines == ({1'b0, height_m1} + 1'b1)));

    // R10
    strobe_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fs_valid |=> !fs_valid);

endmodule

bind lcd_fetch_seq lcd_fetch_seq_chk #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .active(active), .sync_err(sync_err),
    .dma_cond(dma_cond), .dma_irq_frame(dma_irq_frame), .dma_irq_err(dma_irq_err),
    .rd_req(rd_req), .sub_en(sub_en), .height_m1(height_m1),
    .fs_valid(fs_valid), .fs_first(fs_first), .fs_lines(fs_lines), .fs_bpp(fs_bpp)
);

// File: tb/lcd_fetch_seq_tb.sv
module lcd_fetch_seq_tb;
    localparam int AW = 32;
    localparam int DW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic en_wr = 0, en_val = 0, tft = 0, dual = 0, sub_en = 0, sub_first = 0, frame_tick = 0;
    logic [1:0] load_mode = 0, lcd_mask = 0, dma_mask = 0;
    logic [DW-1:0] width_m1 = 10'd15, height_m1 = 10'd7, sub_val = 0;
    logic [AW-1:0] buf0_top = 32'h1000, buf0_bot = 32'h1300, buf1_top = 32'h4000, buf1_bot = 32'h4300;
    logic [AW-1:0] chk_addr, rd_addr, fs_addr;
    logic chk_ok, rd_req, rd_valid = 0;
    logic [15:0] rd_data = 0, pal_rdata;
    logic [7:0] pal_raddr = 0;
    logic active, frame_done, pal_loaded, sync_err, lcd_irq, dma_irq_frame, dma_irq_err, fs_valid, fs_fmt12;
    logic [2:0] dma_cond;
    logic [DW+1:0] fs_stride;
    logic [DW-1:0] fs_first;
    logic [DW:0] fs_lines;
    logic [4:0] fs_bpp;

    lcd_fetch_seq u_dut (.*);

    assign chk_ok = !chk_addr[31];

    // memory contents: header words at the buffer tops, a pattern elsewhere
    logic [15:0] hdr0 = 16'h3055, hdr1 = 16'h3055;
    function automatic logic [15:0] memword(input logic [31:0] a);
        if (a == buf0_top) return hdr0;
        if (a == buf1_top) return hdr1;
        return a[15:0] ^ 16'hA5A5;
    endfunction

    logic pend = 0;
    logic [31:0] pend_addr = 0;
    always @(negedge clk) begin
        rd_valid = 1'b0;
        if (pend) begin
            rd_valid = 1'b1;
            rd_data  = memword(pend_addr);
            pend     = 1'b0;
        end
        if (rd_req) begin
            pend      = 1'b1;
            pend_addr = rd_addr;
        end
    end

    int checks = 0, fails = 0;
    int frame_pulses = 0, err_pulses = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    typedef struct {
        logic [31:0] addr;
        int stride, first, lines, bpp;
        bit fmt12;
    } exp_t;
    exp_t sb[$];

    // monitor: compares every strobe against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (dma_irq_frame) frame_pulses++;
            if (dma_irq_err) err_pulses++;
            if (fs_valid) begin
                if (sb.size() == 0) begin
                    chk(0, "R6 unexpected frame strobe", fs_addr, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(fs_addr == e.addr, "R4 start address", fs_addr, e.addr);
                    chk(fs_stride == e.stride && fs_bpp == e.bpp && fs_fmt12 == e.fmt12,
                        "R3/R10 depth and stride", {fs_bpp, fs_fmt12, fs_stride},
                        {e.bpp[4:0], e.fmt12, e.stride[11:0]});
                    chk(fs_first == e.first && fs_lines == e.lines, "R8 lines",
                        {fs_first, fs_lines}, {e.first[9:0], e.lines[10:0]});
                end
            end
        end
    end

    int exp_idx = 0;
    logic [15:0] last_hdr = 0;

    // driver: models the expected outcome of one tick and pushes it
    task automatic tick_frame(output int kind);
        int code, bpp, hdr, need, room, w, h;
        logic [31:0] top, bot;
        logic [15:0] hw;
        exp_t e;
        kind = 0;
        top = exp_idx ? buf1_top : buf0_top;
        bot = exp_idx ? buf1_bot : buf0_bot;
        if (load_mode != 2'd1) begin
            hw = (load_mode == 2'd2) ? last_hdr : (exp_idx ? hdr1 : hdr0);
            last_hdr = hw;
            code = int'(hw[14:12]);
            bpp = (code == 0) ? 0 : (code == 1) ? 2 : (code == 2) ? 4 : (code == 3) ? 8 : 16;
            hdr = (load_mode == 2'd2) ? 0 : (code >= 3) ? 512 : 32;
            w = int'(width_m1) + 1;
            h = int'(height_m1) + 1;
            need = hdr + w * h * bpp / 8;
            room = int'(bot) - int'(top) + 2;
            if (code == 0) kind = 0;
            else if (need > room) kind = 2;
            else begin
                kind = 1;
                e.addr = top + hdr;
                e.stride = w * bpp / 8;
                e.bpp = bpp;
                e.fmt12 = (code >= 4) && !tft;
                e.first = (sub_en && sub_first) ? int'(sub_val) : 0;
                e.lines = (sub_en && !sub_first) ? int'(sub_val) : h;
                sb.push_back(e);
                if (dual) exp_idx ^= 1;
            end
        end
        @(negedge clk) frame_tick = 1'b1;
        @(negedge clk) frame_tick = 1'b0;
        repeat (12) @(negedge clk);
        chk(sb.size() == 0, "R6 strobe consumed", sb.size(), 0);
    endtask

    task automatic write_en(input logic v);
        @(negedge clk) begin en_wr = 1'b1; en_val = v; end
        @(negedge clk) en_wr = 1'b0;
    endtask

    task automatic wait_loaded();
        for (int i = 0; i < 3000 && !pal_loaded; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int k, p;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!active && !frame_done && !pal_loaded && !sync_err && dma_cond == 0 && !fs_valid,
            "R7 reset state", {active, frame_done, pal_loaded, sync_err, dma_cond}, 0);

        // single buffer, table load
        dma_mask = 2'b01; lcd_mask = 2'b10;
        write_en(1'b1);
        repeat (3) @(negedge clk);
        chk(!pal_loaded && !lcd_irq, "R11 irq low before load", lcd_irq, 0);
        wait_loaded();
        chk(pal_loaded && active, "R2 table loaded", {pal_loaded, active}, 2'b11);
        chk(lcd_irq, "R11 table-loaded interrupt", lcd_irq, 1);
        pal_raddr = 8'd0;   #1 chk(pal_rdata == hdr0, "R2 entry 0", pal_rdata, hdr0);
        pal_raddr = 8'd100; #1 chk(pal_rdata == memword(32'h1000 + 200), "R2 entry 100", pal_rdata, memword(32'h1000 + 200));
        pal_raddr = 8'd255; #1 chk(pal_rdata == memword(32'h1000 + 510), "R2 entry 255", pal_rdata, memword(32'h1000 + 510));

        tick_frame(k);
        chk(dma_cond == 3'b001, "R6 condition bit 0", dma_cond, 1);
        tick_frame(k);
        chk(frame_pulses == 2, "R6 frame pulses", frame_pulses, 2);

        hdr0 = 16'h1055; tick_frame(k);                 // 2 bpp, small header
        hdr0 = 16'h2055; tick_frame(k);                 // 4 bpp
        hdr0 = 16'h5055; tick_frame(k);                 // 16 bpp 12-bit, need equals room-2
        tft = 1; tick_frame(k); tft = 0;
        hdr0 = 16'h0055; tick_frame(k);                 // R3 code 0 skips
        chk(k == 0 && active, "R3 code 0 skipped", active, 1);
        hdr0 = 16'h3055;
        load_mode = 2'd1; p = frame_pulses; tick_frame(k);
        chk(frame_pulses == p, "R9 no fetch in mode 1", frame_pulses, p);
        load_mode = 2'd0; tick_frame(k);
        load_mode = 2'd2; tick_frame(k);                // R4 no header
        load_mode = 2'd0;
        sub_en = 1; sub_first = 1; sub_val = 10'd3; tick_frame(k);
        sub_first = 0; sub_val = 10'd5; tick_frame(k);
        sub_en = 0;

        write_en(1'b0);
        repeat (2) @(negedge clk);
        chk(!active && frame_done && !sync_err, "R7 disable sets frame done",
            {active, frame_done, sync_err}, 3'b010);

        // dual buffers, no DMA pulses
        dma_mask = 2'b00; dual = 1; p = frame_pulses;
        write_en(1'b1);
        repeat (3) @(negedge clk);
        chk(!frame_done && !pal_loaded, "R7 enable from idle clears flags", {frame_done, pal_loaded}, 0);
        exp_idx = 0;
        wait_loaded();
        hdr1 = 16'h3055;
        tick_frame(k);
        tick_frame(k);
        chk(dma_cond[1:0] == 2'b11, "R6 both condition bits", dma_cond, 3);
        tick_frame(k);
        chk(frame_pulses == p, "R6 masked frame pulse", frame_pulses, p);

        // size fault on buffer 1 (next in turn), boundary first
        hdr1 = 16'h5055; buf1_bot = 32'h42FE; tick_frame(k);
        chk(k == 1 && active, "R5 equal size is good", active, 1);
        hdr0 = 16'h5055; buf0_bot = 32'h12FD; tick_frame(k);
        chk(k == 2 && sync_err && !active, "R5 fault disables", {sync_err, active}, 2'b10);
        chk(lcd_irq, "R11 fault interrupt", lcd_irq, 1);
        write_en(1'b0);
        repeat (2) @(negedge clk);
        chk(!frame_done && sync_err, "R12 repeated write ignored", {frame_done, sync_err}, 2'b01);

        // address check faults
        rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
        buf0_bot = 32'h1300; hdr0 = 16'h3055;
        dma_mask = 2'b10; dual = 0; buf1_top = 32'h8000_4000;
        write_en(1'b1);
        repeat (10) @(negedge clk);
        chk(active && dma_cond[2] == 0, "R1 buffer 1 unchecked in single mode", dma_cond, 0);
        write_en(1'b0);
        dual = 1;
        write_en(1'b1);
        repeat (10) @(negedge clk);
        chk(!active && dma_cond[2] && err_pulses == 1, "R1 invalid address",
            {active, dma_cond[2], err_pulses[3:0]}, 6'b010001);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule